// File: doc/BRIEF.md
# Dual-ratio aligned clock divider

This block turns one input clock into two slower clocks whose counters advance together. Bank A divides by 2 or by 4, and one select bit chooses between them. Bank B divides by 4, 5 or 6, and two select bits choose among them. Both banks step on the rising edge of the input clock. They step only when a run flag allows it, and that flag is captured on the falling edge of the clock.

The run flag comes from an active-low input. While the flag says hold, both outputs and both counters stay frozen. Each output is registered, so it can change only on a rising edge. A high or low phase can therefore be stretched by a hold, but never cut short.

A synchronous clear forces both outputs low and restarts both counters, whatever the run input says. Several copies of the block can be cleared together to bring them into phase. After a clear, the first enabled edge raises both outputs at once.

A new ratio is picked up at the start of the next period of the affected bank. Changing a select therefore never produces a partial period.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: With `sel_a_i`=0 bank A divides by 2 (high 1 cycle, low 1). With `sel_a_i`=1 it divides by 4 (high 2, low 2). Cycles are counted in enabled input cycles.
- R2: Bank B decodes `sel_b_i` as follows. 2'b00 divides by 4 (high 2, low 2). 2'b01 divides by 6 (high 3, low 3). 2'b10 and 2'b11 both divide by 5 (high 2, low 3).
- R3: After a clear or a reset, both outputs rise on the first enabled rising edge. Bank X then rises on enabled steps 1, N+1, 2N+1 and so on, so every rising edge the two banks share falls on the same input edge.
- R4: `run_ni` is captured on the falling clock edge, and the captured value governs the next rising edge. Low lets both banks step. High holds both outputs and both counters unchanged.
- R5: `mr_i` high at a rising edge drives both outputs low after that edge and restarts both counters. It does so even while `run_ni` is high.
- R6: A select value is sampled at the enabled edge that starts a period, which is the edge that raises that bank's output. A change in mid-period does not alter the period already running.
- R7: Outside of clears, no high or low phase of either output is shorter than its nominal length for the active ratio, however `run_ni` toggles.
- R8: `rst_ni` low at once forces both outputs low and clears the run flag to hold. The flag stays at hold until the first falling edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_ni | input | 1 | Run enable, active low, captured on the falling edge |
| mr_i | input | 1 | Synchronous clear of both banks, active high |
| sel_a_i | input | 1 | Bank A ratio select: 0 for /2, 1 for /4 |
| sel_b_i | input | 2 | Bank B ratio select: 00 for /4, 01 for /6, 1x for /5 |
| div_a_o | output | 1 | Bank A divided clock |
| div_b_o | output | 1 | Bank B divided clock |

## Verification
The bench builds the block with its default ratio parameters (2/4 and 4/6/5). This keeps every period at six cycles or less, so all eight select combinations can be swept in full. Each sweep is long enough that the number of shared rising edges can be counted and compared with an arithmetic prediction. The small periods also let long runs with a pseudo-random run input cover every counter phase in which a hold can start or end. Selects are changed in mid-period to check when a new ratio is picked up. Clear while holding and asynchronous reset mid-run are each exercised.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam logic [1:0] SELB_QUARTER = 2'b00;
  localparam logic [1:0] SELB_SIXTH   = 2'b01;

  function automatic int unsigned max5(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d,
                                       input int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction
endpackage

// File: rtl/clkdiv_run_gate.sv
// Run flag captured on the falling edge so gating only moves while clk is low.
module clkdiv_run_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_ni,
  output logic run_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_o <= 1'b0;
    else         run_o <= ~run_ni;
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          clr_i,
  input  logic [CW-1:0] ratio_i,
  output logic          q_o
);
  logic [CW-1:0] cnt_q, ratio_q, eff, cnt_nx;
  logic          start;

  // ratio is latched only when a period starts (count 0)
  assign start  = (cnt_q == '0);
  assign eff    = start ? ratio_i : ratio_q;
  assign cnt_nx = (cnt_q == eff - 1'b1) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      q_o     <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      q_o   <= 1'b0;
    end else if (step_i) begin
      cnt_q <= cnt_nx;
      q_o   <= (cnt_nx != '0) && (cnt_nx <= (eff >> 1));
      if (start) ratio_q <= ratio_i;
    end
  end
endmodule

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv #(
  parameter int unsigned DIV_A_LO = 2,
  parameter int unsigned DIV_A_HI = 4,
  parameter int unsigned DIV_B_00 = 4,
  parameter int unsigned DIV_B_01 = 6,
  parameter int unsigned DIV_B_1X = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_ni,
  input  logic       mr_i,
  input  logic       sel_a_i,
  input  logic [1:0] sel_b_i,
  output logic       div_a_o,
  output logic       div_b_o
);
  import clkdiv_pkg::*;

  localparam int unsigned MAXR   = max5(DIV_A_LO, DIV_A_HI, DIV_B_00, DIV_B_01, DIV_B_1X);
  localparam int unsigned CW     = $clog2(MAXR + 1);
  localparam int unsigned NBANKS = 2;

  logic          run_q;
  logic [CW-1:0] ratio [NBANKS];
  logic          qv    [NBANKS];

  clkdiv_run_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_ni (run_ni),
    .run_o  (run_q)
  );

  always_comb begin
    ratio[0] = sel_a_i ? CW'(DIV_A_HI) : CW'(DIV_A_LO);
    case (sel_b_i)
      SELB_QUARTER: ratio[1] = CW'(DIV_B_00);
      SELB_SIXTH:   ratio[1] = CW'(DIV_B_01);
      default:      ratio[1] = CW'(DIV_B_1X);
    endcase
  end

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    clkdiv_bank #(.CW(CW)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (run_q),
      .clr_i   (mr_i),
      .ratio_i (ratio[g]),
      .q_o     (qv[g])
    );
  end

  assign div_a_o = qv[0];
  assign div_b_o = qv[1];
endmodule

module dual_ratio_clkdiv_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mr_i,
  input logic run_i,
  input logic div_a_i,
  input logic div_b_i
);
  a_r5_clear_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_i |=> (!div_a_i && !div_b_i));

  a_r4_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !mr_i) |=> $stable({div_a_i, div_b_i}));

  a_r3_joint_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mr_i) && !mr_i && run_i) |=> (div_a_i && div_b_i));

  a_r2_b_high_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(div_b_i) && run_i && !mr_i) |=> div_b_i);

  a_r7_b_low_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(div_b_i) && !$past(mr_i)) |=> !div_b_i);
endmodule

bind dual_ratio_clkdiv dual_ratio_clkdiv_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mr_i    (mr_i),
  .run_i   (run_q),
  .div_a_i (div_a_o),
  .div_b_i (div_b_o)
);

// File: tb/sim_dual_ratio_clkdiv.sv
`timescale 1ns/1ps
module sim_dual_ratio_clkdiv;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_ni = 1'b0;
  logic       mr_i = 1'b0;
  logic       sel_a_i = 1'b0;
  logic [1:0] sel_b_i = 2'b00;
  logic       div_a_o, div_b_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state per bank
  int p [2];
  int n [2];
  bit q [2];

  // pulse width monitor
  bit mon_on = 0;
  bit mon_seen [2];
  bit mon_last [2];
  int mon_len  [2];
  int mon_ratio [2];

  always #10 clk = ~clk;

  dual_ratio_clkdiv u0 (
    .clk_i(clk), .rst_ni(rst_ni), .run_ni(run_ni), .mr_i(mr_i),
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .div_a_o(div_a_o), .div_b_o(div_b_o)
  );

  function automatic int ratio_a(input bit sa);
    return sa ? 4 : 2;
  endfunction

  function automatic int ratio_b(input logic [1:0] sb);
    if (sb == 2'b00) return 4;
    if (sb == 2'b01) return 6;
    return 5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      p[i] = 0; q[i] = 0; n[i] = 2;
      mon_seen[i] = 0; mon_len[i] = 0; mon_last[i] = 0;
    end
  endtask

  // one input cycle: drive, pass the rising edge, update model, compare
  task automatic cyc(input bit rn, input bit m, input bit sa, input logic [1:0] sb,
                     input string ta, input string tb);
    int nn [2];
    bit dv [2];
    run_ni = rn; mr_i = m; sel_a_i = sa; sel_b_i = sb;
    @(posedge clk); #1;
    nn[0] = ratio_a(sa); nn[1] = ratio_b(sb);
    for (int i = 0; i < 2; i++) begin
      if (m) begin
        p[i] = 0; q[i] = 0;
      end else if (!rn) begin
        if (p[i] == 0) n[i] = nn[i];
        p[i] = (p[i] + 1) % n[i];
        q[i] = (p[i] >= 1) && (p[i] <= n[i] / 2);
      end
    end
    dv[0] = div_a_o; dv[1] = div_b_o;
    chk(dv[0] == q[0], ta, dv[0], q[0]);
    chk(dv[1] == q[1], tb, dv[1], q[1]);
    if (mon_on) begin
      for (int i = 0; i < 2; i++) begin
        if (dv[i] == mon_last[i]) mon_len[i]++;
        else begin
          if (mon_seen[i])
            chk(mon_len[i] >= (mon_last[i] ? mon_ratio[i] / 2 : mon_ratio[i] - mon_ratio[i] / 2),
                "R7", mon_len[i],
                mon_last[i] ? mon_ratio[i] / 2 : mon_ratio[i] - mon_ratio[i] / 2);
          mon_seen[i] = 1;
          mon_len[i] = 1;
        end
        mon_last[i] = dv[i];
      end
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    // R8: reset state
    #35;
    chk(div_a_o == 1'b0, "R8", div_a_o, 0);
    chk(div_b_o == 1'b0, "R8", div_b_o, 0);
    @(posedge clk); #1; rst_ni = 1'b1;

    // R1/R2/R3: sweep every select combination from a clear
    for (int c = 0; c < 8; c++) begin
      bit sa;
      logic [1:0] sb;
      int both, exp_both, na, nb;
      bit pa, pb;
      sa = c[2]; sb = c[1:0];
      na = ratio_a(sa); nb = ratio_b(sb);
      cyc(0, 1, sa, sb, "R5", "R5");
      cyc(0, 0, sa, sb, "R1", "R2");
      chk(div_a_o && div_b_o, "R3", {div_a_o, div_b_o}, 3);
      both = 1; exp_both = 0; pa = 1; pb = 1;
      for (int s = 2; s <= 60; s++) begin
        cyc(0, 0, sa, sb, "R1", "R2");
        if (div_a_o && !pa && div_b_o && !pb) both++;
        pa = div_a_o; pb = div_b_o;
      end
      for (int s = 1; s <= 60; s++)
        if (((s - 1) % na == 0) && ((s - 1) % nb == 0)) exp_both++;
      chk(both == exp_both, "R3", both, exp_both);
    end

    // R6: select changes in mid-period
    cyc(0, 1, 0, 2'b00, "R5", "R5");
    for (int s = 0; s < 3; s++) cyc(0, 0, 0, 2'b00, "R6", "R6");
    for (int s = 0; s < 14; s++) cyc(0, 0, 1, 2'b01, "R6", "R6");
    for (int s = 0; s < 9; s++)  cyc(0, 0, 0, 2'b11, "R6", "R6");
    for (int s = 0; s < 13; s++) cyc(0, 0, 1, 2'b10, "R6", "R6");

    // R4/R7: pseudo-random run input, fixed selects
    lfsr = 16'hACE1;
    for (int k = 0; k < 2; k++) begin
      bit sa;
      logic [1:0] sb;
      sa = (k == 0); sb = (k == 0) ? 2'b10 : 2'b01;
      cyc(0, 1, sa, sb, "R5", "R5");
      mon_ratio[0] = ratio_a(sa); mon_ratio[1] = ratio_b(sb);
      for (int i = 0; i < 2; i++) begin mon_seen[i] = 0; mon_len[i] = 0; mon_last[i] = 0; end
      mon_on = 1;
      for (int s = 0; s < 400; s++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cyc(lfsr[0] & lfsr[3], 0, sa, sb, "R4", "R4");
      end
      mon_on = 0;
    end

    // R5: clear wins over hold, then joint start
    for (int s = 0; s < 3; s++) cyc(0, 0, 1, 2'b01, "R4", "R4");
    cyc(1, 1, 1, 2'b01, "R5", "R5");
    chk(!div_a_o && !div_b_o, "R5", {div_a_o, div_b_o}, 0);
    cyc(1, 0, 1, 2'b01, "R4", "R4");
    cyc(0, 0, 1, 2'b01, "R3", "R3");
    chk(div_a_o && div_b_o, "R3", {div_a_o, div_b_o}, 3);

    // R8: asynchronous reset mid-run
    for (int s = 0; s < 2; s++) cyc(0, 0, 0, 2'b10, "R2", "R2");
    rst_ni = 1'b0; #1;
    chk(!div_a_o && !div_b_o, "R8", {div_a_o, div_b_o}, 0);
    model_reset();
    @(posedge clk); #1;
    chk(!div_a_o && !div_b_o, "R8", {div_a_o, div_b_o}, 0);
    rst_ni = 1'b1;
    for (int s = 0; s < 12; s++) cyc(0, 0, 0, 2'b10, "R8", "R8");

    done = 1;
    summary();
    $finish;
  end
endmodule